// File: doc/BRIEF.md
# Flash Program/Erase Operation Sequencer

This block runs the internal program and erase operations of a two-bank flash array. A command decoder hands it one request at a time: program a word in a sector, erase one sector, erase one block of sectors, or erase the whole chip. The block stands in for the array timing with a cycle counter per operation. It reports which bank is busy, so that the other bank can still be read. It also drives a ready/busy line and raises a one-cycle pulse when an operation completes.

A running sector or block erase can be suspended. After a fixed latency, the erase stops and the bank becomes readable. While the erase is suspended, programs are accepted into any sector outside the paused region. A resume request continues the erase where it stopped.

A write-protect input locks the four outermost sectors of the smaller bank and refuses chip erase. A hardware reset pin that is held low long enough aborts all work. A recovery interval must then pass before reads are allowed.

Requests arrive on a valid/ready handshake. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. The requester holds its request stable while ready is low. A request that is taken but not permitted is dropped without effect.

Top module: `flash_op_sequencer`

## Requirements
- R1: `req_ready_o` is high only while reads are permitted, the reset pin is high, and the sequencer is either idle or suspended with no program running and no resume requested. While any operation runs, ready stays low.
- R2: An accepted operation keeps its bank busy for exactly its duration in cycles: T_PROG for op code 0 (program), T_SERASE for 1 (sector erase), T_BERASE for 2 (block erase) and T_CERASE for 3 (chip erase). `done_o` is high for the single cycle in which busy has just fallen.
- R3: Sectors 0 to 127 form bank 0, shown on `bank_busy_o[0]`, and sectors 128 to 511 form bank 1, shown on `bank_busy_o[1]`. Program and sector erase flag the bank of their sector. Block erase flags the bank of the block, where a block is 16 aligned sectors and the low 4 sector bits are ignored. Chip erase flags both banks.
- R4: `ryby_o` is low exactly while some bank is busy. It is high when idle and while an erase is suspended.
- R5: A suspend pulse during a sector or block erase keeps the bank busy for T_SUSP further cycles. After that, busy drops and `susp_active_o` rises, with `susp_sect_o` holding the erased sector (for a block erase, its base sector) and `susp_blk_o` marking a block erase. Suspend has no effect on program or chip erase.
- R6: While suspended, a program outside the paused sector or block runs normally and `susp_active_o` stays high. A program inside the paused region, and any erase request, is dropped with no busy and no done.
- R7: A resume pulse while suspended restarts the erase. The erase finishes after its remaining cycles, so its total busy time is T_SERASE or T_BERASE plus T_SUSP, and `susp_active_o` clears.
- R8: With `wp_ni` low, programs and erases that touch sectors 0 to 3 are dropped, and so is chip erase. Sectors outside that range are unaffected.
- R9: If `pin_rst_ni` is low for T_RST_MIN consecutive clock edges, all work is aborted: busy clears, suspension clears and no done pulse is raised. A low pulse shorter than that has no effect.
- R10: After an abort, `rd_ok_o` stays low while the pin is held low, and then for exactly T_RST_REC cycles after the pin is released. Requests are refused during that time.
- R11: If a suspend pulse arrives in the last cycle of an erase, the erase completes with a done pulse and no suspension. One cycle earlier, the suspension takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_op_i | input | 2 | Operation: 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_sect_i | input | 9 | Target sector index |
| susp_req_i | input | 1 | Erase suspend pulse |
| resume_req_i | input | 1 | Erase resume pulse |
| wp_ni | input | 1 | Write protect, active low |
| pin_rst_ni | input | 1 | Hardware reset pin, active low |
| bank_busy_o | output | 2 | Per-bank busy flags |
| ryby_o | output | 1 | Ready (1) / busy (0) |
| done_o | output | 1 | One-cycle completion pulse |
| susp_active_o | output | 1 | An erase is suspended |
| susp_sect_o | output | 9 | Sector (or block base) of the suspended erase |
| susp_blk_o | output | 1 | The suspended erase is a block erase |
| rd_ok_o | output | 1 | Array reads are permitted |

## Verification
The key collision is a suspend request that arrives on the clock edge where a sector erase reaches its final count. The bench places the suspend pulse exactly on the last busy cycle of an erase. It expects a done pulse, idle banks and no suspension. It then repeats the test one cycle earlier and expects a suspension instead. After a resume, the total busy time must equal the erase duration plus the suspend latency, which shows that no erase cycle was lost or counted twice.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_PROG       = 2'd0,
    OP_SECT_ERASE = 2'd1,
    OP_BLK_ERASE  = 2'd2,
    OP_CHIP_ERASE = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_SWAIT,
    ST_SUSP,
    ST_SPROG
  } seq_st_e;
endpackage

// File: rtl/flash_seq_guard.sv
module flash_seq_guard
  import flash_seq_pkg::*;
#(
  parameter int SECT_W       = 9,
  parameter int SMALL_SECT   = 128,
  parameter int BLK_LG       = 4,
  parameter int PROT_SECT    = 4,
  parameter bit BOTTOM_SMALL = 1'b1,
  parameter int CNT_W        = 6,
  parameter int T_PROG       = 6,
  parameter int T_SERASE     = 30,
  parameter int T_BERASE     = 36,
  parameter int T_CERASE     = 50
) (
  input  op_e               op_i,
  input  logic [SECT_W-1:0] sect_i,
  input  logic              wp_ni,
  input  logic              in_susp_i,
  input  logic [SECT_W-1:0] susp_sect_i,
  input  logic              susp_blk_i,
  output logic              allow_o,
  output logic [1:0]        bank_o,
  output logic [SECT_W-1:0] target_o,
  output logic [CNT_W-1:0]  dur_o
);
  localparam int NSECT = 1 << SECT_W;
  localparam int SPLIT = BOTTOM_SMALL ? SMALL_SECT : NSECT - SMALL_SECT;
  localparam int PLO   = BOTTOM_SMALL ? 0 : NSECT - PROT_SECT;
  localparam int PHI   = BOTTOM_SMALL ? PROT_SECT - 1 : NSECT - 1;
  localparam logic [SECT_W-1:0] SPLIT_V = SECT_W'(SPLIT);
  localparam logic [SECT_W-1:0] PLO_V   = SECT_W'(PLO);
  localparam logic [SECT_W-1:0] PHI_V   = SECT_W'(PHI);

  logic [SECT_W-1:0] lo, hi;
  logic              prot, clash;

  always_comb begin
    if (op_i == OP_BLK_ERASE) begin
      lo = {sect_i[SECT_W-1:BLK_LG], {BLK_LG{1'b0}}};
      hi = {sect_i[SECT_W-1:BLK_LG], {BLK_LG{1'b1}}};
    end else begin
      lo = sect_i;
      hi = sect_i;
    end
    prot  = (op_i == OP_CHIP_ERASE) || ((lo <= PHI_V) && (hi >= PLO_V));
    clash = susp_blk_i ? (sect_i[SECT_W-1:BLK_LG] == susp_sect_i[SECT_W-1:BLK_LG])
                       : (sect_i == susp_sect_i);
    allow_o  = !(!wp_ni && prot) && (!in_susp_i || (op_i == OP_PROG && !clash));
    target_o = lo;
    if (op_i == OP_CHIP_ERASE) bank_o = 2'b11;
    else if (lo >= SPLIT_V)    bank_o = 2'b10;
    else                       bank_o = 2'b01;
    unique case (op_i)
      OP_PROG:       dur_o = CNT_W'(T_PROG);
      OP_SECT_ERASE: dur_o = CNT_W'(T_SERASE);
      OP_BLK_ERASE:  dur_o = CNT_W'(T_BERASE);
      default:       dur_o = CNT_W'(T_CERASE);
    endcase
  end
endmodule

// File: rtl/flash_seq_rstmon.sv
module flash_seq_rstmon #(
  parameter int T_RST_MIN = 3,
  parameter int T_RST_REC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_rst_ni,
  output logic abort_o,
  output logic rd_ok_o
);
  localparam int LW = $clog2(T_RST_MIN + 1);
  localparam int RW = $clog2(T_RST_REC + 1);
  localparam logic [LW-1:0] LOW_LAST = LW'(T_RST_MIN - 1);

  logic [LW-1:0] low_q;
  logic [RW-1:0] rec_q;
  logic          hold_q;

  assign abort_o = !pin_rst_ni && (low_q == LOW_LAST);
  assign rd_ok_o = !hold_q && (rec_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= '0;
      rec_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      if (pin_rst_ni)             low_q <= '0;
      else if (low_q != LOW_LAST) low_q <= low_q + 1'b1;

      if (abort_o) begin
        hold_q <= 1'b1;
        rec_q  <= '0;
      end else if (hold_q && pin_rst_ni) begin
        hold_q <= 1'b0;
        rec_q  <= RW'(T_RST_REC);
      end else if (rec_q != '0) begin
        rec_q <= rec_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int SECT_W = 9,
  parameter int CNT_W  = 6,
  parameter int T_SUSP = 4,
  parameter int T_PROG = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              rd_ok_i,
  input  logic              pin_rst_ni,
  input  logic              req_valid_i,
  input  op_e               req_op_i,
  input  logic              allow_i,
  input  logic [1:0]        bank_i,
  input  logic [SECT_W-1:0] target_i,
  input  logic [CNT_W-1:0]  dur_i,
  input  logic              susp_req_i,
  input  logic              resume_req_i,
  output logic              req_ready_o,
  output logic              in_susp_o,
  output logic [SECT_W-1:0] paused_sect_o,
  output logic              paused_blk_o,
  output logic [1:0]        bank_busy_o,
  output logic              ryby_o,
  output logic              done_o,
  output logic              susp_active_o,
  output logic [SECT_W-1:0] susp_sect_o,
  output logic              susp_blk_o
);
  localparam int WW = $clog2(T_SUSP + 1);

  seq_st_e           st_q;
  op_e               op_q;
  logic [1:0]        bank_q, pbank_q;
  logic [SECT_W-1:0] targ_q;
  logic [CNT_W-1:0]  rem_q, pcnt_q;
  logic [WW-1:0]     wcnt_q;
  logic              done_q;
  logic              accept, can_pause;

  assign req_ready_o = rd_ok_i && pin_rst_ni &&
                       ((st_q == ST_IDLE) || (st_q == ST_SUSP && !resume_req_i));
  assign accept      = req_valid_i && req_ready_o;
  assign can_pause   = (op_q == OP_SECT_ERASE) || (op_q == OP_BLK_ERASE);

  assign in_susp_o     = (st_q == ST_SUSP) || (st_q == ST_SPROG);
  assign paused_sect_o = targ_q;
  assign paused_blk_o  = (op_q == OP_BLK_ERASE);
  assign susp_active_o = in_susp_o;
  assign susp_sect_o   = in_susp_o ? targ_q : '0;
  assign susp_blk_o    = in_susp_o && (op_q == OP_BLK_ERASE);
  assign ryby_o        = (st_q == ST_IDLE) || (st_q == ST_SUSP);
  assign done_o        = done_q;

  always_comb begin
    unique case (st_q)
      ST_RUN, ST_SWAIT: bank_busy_o = bank_q;
      ST_SPROG:         bank_busy_o = pbank_q;
      default:          bank_busy_o = 2'b00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_PROG;
      bank_q  <= 2'b00;
      pbank_q <= 2'b00;
      targ_q  <= '0;
      rem_q   <= '0;
      pcnt_q  <= '0;
      wcnt_q  <= '0;
      done_q  <= 1'b0;
    end else if (abort_i) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept && allow_i) begin
          st_q   <= ST_RUN;
          rem_q  <= dur_i;
          op_q   <= req_op_i;
          bank_q <= bank_i;
          targ_q <= target_i;
        end
        ST_RUN: if (rem_q == CNT_W'(1)) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end else begin
          rem_q <= rem_q - 1'b1;
          if (susp_req_i && can_pause) begin
            st_q   <= ST_SWAIT;
            wcnt_q <= WW'(T_SUSP);
          end
        end
        ST_SWAIT: if (wcnt_q == WW'(1)) st_q <= ST_SUSP;
                  else wcnt_q <= wcnt_q - 1'b1;
        ST_SUSP: if (resume_req_i) begin
          st_q <= ST_RUN;
        end else if (accept && allow_i) begin
          st_q    <= ST_SPROG;
          pcnt_q  <= CNT_W'(T_PROG);
          pbank_q <= bank_i;
        end
        ST_SPROG: if (pcnt_q == CNT_W'(1)) begin
          st_q   <= ST_SUSP;
          done_q <= 1'b1;
        end else begin
          pcnt_q <= pcnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
  import flash_seq_pkg::*;
#(
  parameter int SECT_W       = 9,
  parameter int SMALL_SECT   = 128,
  parameter int BLK_LG       = 4,
  parameter int PROT_SECT    = 4,
  parameter bit BOTTOM_SMALL = 1'b1,
  parameter int T_PROG       = 6,
  parameter int T_SERASE     = 30,
  parameter int T_BERASE     = 36,
  parameter int T_CERASE     = 50,
  parameter int T_SUSP       = 4,
  parameter int T_RST_MIN    = 3,
  parameter int T_RST_REC    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [SECT_W-1:0] req_sect_i,
  input  logic              susp_req_i,
  input  logic              resume_req_i,
  input  logic              wp_ni,
  input  logic              pin_rst_ni,
  output logic [1:0]        bank_busy_o,
  output logic              ryby_o,
  output logic              done_o,
  output logic              susp_active_o,
  output logic [SECT_W-1:0] susp_sect_o,
  output logic              susp_blk_o,
  output logic              rd_ok_o
);
  localparam int M1    = (T_PROG > T_SERASE) ? T_PROG : T_SERASE;
  localparam int M2    = (M1 > T_BERASE) ? M1 : T_BERASE;
  localparam int MAXD  = (M2 > T_CERASE) ? M2 : T_CERASE;
  localparam int CNT_W = $clog2(MAXD + 1);

  op_e               op;
  logic              abort, allow, in_susp, paused_blk;
  logic [1:0]        bank;
  logic [SECT_W-1:0] target, paused_sect;
  logic [CNT_W-1:0]  dur;

  assign op = op_e'(req_op_i);

  flash_seq_guard #(
    .SECT_W(SECT_W), .SMALL_SECT(SMALL_SECT), .BLK_LG(BLK_LG),
    .PROT_SECT(PROT_SECT), .BOTTOM_SMALL(BOTTOM_SMALL), .CNT_W(CNT_W),
    .T_PROG(T_PROG), .T_SERASE(T_SERASE), .T_BERASE(T_BERASE), .T_CERASE(T_CERASE)
  ) u_guard (
    .op_i(op), .sect_i(req_sect_i), .wp_ni(wp_ni), .in_susp_i(in_susp),
    .susp_sect_i(paused_sect), .susp_blk_i(paused_blk),
    .allow_o(allow), .bank_o(bank), .target_o(target), .dur_o(dur)
  );

  flash_seq_rstmon #(.T_RST_MIN(T_RST_MIN), .T_RST_REC(T_RST_REC)) u_rstmon (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_rst_ni(pin_rst_ni),
    .abort_o(abort), .rd_ok_o(rd_ok_o)
  );

  flash_seq_ctrl #(.SECT_W(SECT_W), .CNT_W(CNT_W), .T_SUSP(T_SUSP), .T_PROG(T_PROG)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .abort_i(abort), .rd_ok_i(rd_ok_o),
    .pin_rst_ni(pin_rst_ni), .req_valid_i(req_valid_i), .req_op_i(op),
    .allow_i(allow), .bank_i(bank), .target_i(target), .dur_i(dur),
    .susp_req_i(susp_req_i), .resume_req_i(resume_req_i),
    .req_ready_o(req_ready_o), .in_susp_o(in_susp), .paused_sect_o(paused_sect),
    .paused_blk_o(paused_blk), .bank_busy_o(bank_busy_o), .ryby_o(ryby_o),
    .done_o(done_o), .susp_active_o(susp_active_o), .susp_sect_o(susp_sect_o),
    .susp_blk_o(susp_blk_o)
  );
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int SECT_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [1:0]        req_op_i,
  input logic              wp_ni,
  input logic [1:0]        bank_busy_o,
  input logic              ryby_o,
  input logic              done_o,
  input logic              susp_active_o,
  input logic [SECT_W-1:0] susp_sect_o,
  input logic              rd_ok_o
);
  a_r4_ryby_tracks_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ryby_o == (bank_busy_o == 2'b00));

  a_r1_ready_only_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (ryby_o && rd_ok_o));

  a_r2_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(bank_busy_o) != 2'b00));

  a_r5_suspend_releases_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(susp_active_o) |-> (ryby_o && $past(!ryby_o)));

  a_r6_paused_id_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_active_o && $past(susp_active_o)) |-> $stable(susp_sect_o));

  a_r8_chip_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !wp_ni && req_op_i == 2'd3) |=> (bank_busy_o == 2'b00));

  a_r9_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_ok_o) |-> (bank_busy_o == 2'b00 && !susp_active_o && !done_o));
endmodule

bind flash_op_sequencer flash_seq_chk #(.SECT_W(SECT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_op_i(req_op_i), .wp_ni(wp_ni), .bank_busy_o(bank_busy_o), .ryby_o(ryby_o),
  .done_o(done_o), .susp_active_o(susp_active_o), .susp_sect_o(susp_sect_o),
  .rd_ok_o(rd_ok_o)
);

// File: tb/flash_op_sequencer_bench.sv
module flash_op_sequencer_bench;
  localparam int T_PROG = 6, T_SERASE = 30, T_BERASE = 36, T_CERASE = 50;
  localparam int T_SUSP = 4, T_RST_MIN = 3, T_RST_REC = 5;
  localparam logic [1:0] PRG = 2'd0, SER = 2'd1, BER = 2'd2, CHP = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = 2'd0;
  logic [8:0] req_sect = '0;
  logic susp = 1'b0, resume = 1'b0, wp_n = 1'b1, pin_n = 1'b1;
  logic [1:0] busy;
  logic ryby, done, sact, sblk, rd_ok;
  logic [8:0] ssect;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_op_sequencer #(
    .T_PROG(T_PROG), .T_SERASE(T_SERASE), .T_BERASE(T_BERASE), .T_CERASE(T_CERASE),
    .T_SUSP(T_SUSP), .T_RST_MIN(T_RST_MIN), .T_RST_REC(T_RST_REC)
  ) u_flash_op_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_sect_i(req_sect), .susp_req_i(susp), .resume_req_i(resume),
    .wp_ni(wp_n), .pin_rst_ni(pin_n), .bank_busy_o(busy), .ryby_o(ryby), .done_o(done),
    .susp_active_o(sact), .susp_sect_o(ssect), .susp_blk_o(sblk), .rd_ok_o(rd_ok)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Starts and ends just after a falling edge; returns on the first cycle after acceptance.
  task automatic send(input logic [1:0] op, input int sect);
    req_valid = 1'b1; req_op = op; req_sect = 9'(sect);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain(inout int n);
    while (busy != 2'b00) begin n++; @(negedge clk); end
  endtask

  task automatic pulse_susp(inout int n);
    susp = 1'b1;
    if (busy != 2'b00) n++;
    @(negedge clk);
    susp = 1'b0;
  endtask

  task automatic pulse_resume();
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
  endtask

  task automatic t_reset();
    chk("R4 idle ryby", ryby, 1);
    chk("R3 idle busy", busy, 0);
    chk("R1 idle ready", req_ready, 1);
    chk("R10 idle rd_ok", rd_ok, 1);
    chk("R5 idle susp", sact, 0);
  endtask

  task automatic t_program();
    int n = 0;
    send(PRG, 200);
    chk("R3 program bank1", busy, 2);
    chk("R4 ryby low", ryby, 0);
    chk("R1 ready low busy", req_ready, 0);
    drain(n);
    chk("R2 program cycles", n, T_PROG);
    chk("R2 program done", done, 1);
    @(negedge clk);
    chk("R2 done one cycle", done, 0);
  endtask

  task automatic t_erases();
    int n = 0;
    send(SER, 10);
    chk("R3 sector bank0", busy, 1);
    drain(n);
    chk("R2 sector cycles", n, T_SERASE);
    chk("R2 sector done", done, 1);
    n = 0;
    send(BER, 40);
    chk("R3 block bank0", busy, 1);
    drain(n);
    chk("R2 block cycles", n, T_BERASE);
    n = 0;
    send(CHP, 0);
    chk("R3 chip both banks", busy, 3);
    drain(n);
    chk("R2 chip cycles", n, T_CERASE);
    chk("R2 chip done", done, 1);
  endtask

  task automatic t_wp();
    int n = 0;
    wp_n = 1'b0;
    send(PRG, 2);
    chk("R8 program sect2 dropped", busy, 0);
    chk("R8 no done", done, 0);
    send(BER, 5);
    chk("R8 block0 dropped", busy, 0);
    send(CHP, 300);
    chk("R8 chip dropped", busy, 0);
    send(SER, 3);
    chk("R8 sector3 dropped", busy, 0);
    chk("R8 no done later", done, 0);
    send(PRG, 4);
    drain(n);
    chk("R8 sect4 programs", n, T_PROG);
    wp_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_suspend();
    int n = 0, m = 0;
    send(SER, 300);
    repeat (4) begin if (busy != 2'b00) n++; @(negedge clk); end
    pulse_susp(n);
    drain(n);
    chk("R5 suspended", sact, 1);
    chk("R5 paused sector", ssect, 300);
    chk("R5 not block", sblk, 0);
    chk("R4 ryby high suspended", ryby, 1);
    chk("R1 ready suspended", req_ready, 1);
    chk("R5 latency", n, 4 + 1 + T_SUSP);
    send(PRG, 300);
    chk("R6 same sector dropped", busy, 0);
    send(SER, 20);
    chk("R6 erase dropped", busy, 0);
    chk("R6 no done", done, 0);
    send(PRG, 301);
    chk("R6 program bank1", busy, 2);
    drain(m);
    chk("R6 program cycles", m, T_PROG);
    chk("R6 program done", done, 1);
    chk("R6 still suspended", sact, 1);
    pulse_resume();
    drain(n);
    chk("R7 total erase cycles", n, T_SERASE + T_SUSP);
    chk("R7 done", done, 1);
    chk("R7 suspension cleared", sact, 0);
    n = 0; m = 0;
    send(BER, 52);
    repeat (2) @(negedge clk);
    pulse_susp(n);
    drain(n);
    chk("R5 block base", ssect, 48);
    chk("R5 block flag", sblk, 1);
    send(PRG, 50);
    chk("R6 same block dropped", busy, 0);
    send(PRG, 64);
    drain(m);
    chk("R6 other block programs", m, T_PROG);
    pulse_resume();
    drain(n);
    chk("R7 block done", done, 1);
  endtask

  task automatic t_susp_ignored();
    int n = 0;
    send(PRG, 7);
    pulse_susp(n);
    drain(n);
    chk("R5 program ignores suspend", n, T_PROG);
    chk("R5 no suspension program", sact, 0);
    n = 0;
    send(CHP, 0);
    repeat (3) begin n++; @(negedge clk); end
    pulse_susp(n);
    drain(n);
    chk("R5 chip ignores suspend", n, T_CERASE);
    chk("R5 no suspension chip", sact, 0);
  endtask

  task automatic t_race();
    int n = 0;
    send(SER, 100);
    repeat (T_SERASE - 1) begin if (busy != 2'b00) n++; @(negedge clk); end
    pulse_susp(n);
    chk("R11 last cycle completes", done, 1);
    chk("R11 no suspension", sact, 0);
    chk("R11 idle", busy, 0);
    chk("R11 cycles", n, T_SERASE);
    n = 0;
    send(SER, 100);
    repeat (T_SERASE - 2) begin if (busy != 2'b00) n++; @(negedge clk); end
    pulse_susp(n);
    drain(n);
    chk("R11 one earlier suspends", sact, 1);
    pulse_resume();
    drain(n);
    chk("R11 resumed total", n, T_SERASE + T_SUSP);
  endtask

  task automatic t_rst_short();
    int n = 0, low = 0;
    send(SER, 130);
    pin_n = 1'b0;
    repeat (T_RST_MIN - 1) begin
      if (busy != 2'b00) n++;
      if (!rd_ok) low++;
      @(negedge clk);
    end
    pin_n = 1'b1;
    drain(n);
    chk("R9 short pulse no abort", n, T_SERASE);
    chk("R9 short pulse done", done, 1);
    chk("R10 rd_ok kept", low, 0);
  endtask

  task automatic t_rst_abort();
    int n = 0, rdy = 0;
    bit saw = 1'b0;
    send(SER, 300);
    repeat (3) @(negedge clk);
    pulse_susp(n);
    drain(n);
    send(PRG, 310);
    pin_n = 1'b0;
    repeat (T_RST_MIN + 2) begin if (done) saw = 1'b1; @(negedge clk); end
    chk("R9 busy cleared", busy, 0);
    chk("R9 suspension cleared", sact, 0);
    chk("R9 no done", int'(saw) | int'(done), 0);
    chk("R10 rd_ok low held", rd_ok, 0);
    chk("R10 ready low held", req_ready, 0);
    pin_n = 1'b1;
    @(negedge clk);
    n = 0;
    while (!rd_ok) begin n++; if (req_ready) rdy++; @(negedge clk); end
    chk("R10 recovery cycles", n, T_RST_REC);
    chk("R10 ready refused", rdy, 0);
    chk("R1 ready after recovery", req_ready, 1);
    n = 0;
    send(PRG, 5);
    drain(n);
    chk("R9 fresh program", n, T_PROG);
    chk("R9 fresh done", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_erases();
    t_wp();
    t_suspend();
    t_susp_ignored();
    t_race();
    t_rst_short();
    t_rst_abort();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule